// File: doc/BRIEF.md
# Resource Group Unit Selector

This block manages one execution resource built from up to `UNIT_W` interchangeable units, each unit standing for one bit of a mask. A scheduler asks it which unit to use next: the block offers the highest unit still left in its current rotation. When a select is taken, that unit leaves the rotation. Once the rotation runs empty, it refills from the full unit set. An instruction that is tied to one specific unit claims that unit statically. The claimed unit is taken out of the rotation. If the unit had already left the rotation, the claim is remembered and applied when the rotation next refills.

Alongside the rotation, the block keeps a mask of units that are free this cycle. A use request toggles a unit's bit off and a release request toggles it back on. From this mask it reports whether a requested number of units is free. The block also holds a reservation flag and a counter of free dispatch-buffer slots. The `BUF_SIZE` parameter sets how the counter behaves: -1 means no buffer, 0 means the resource blocks dispatch while it is reserved, 1 means in-order, and a larger value means a buffer of that depth. A two-bit status tells the dispatcher whether it may send work to this resource.

Top module: `rgs_unit_sel`

## Requirements
- R1: After reset, the offered unit is the highest bit of the unit set, every unit of the set is free, the resource is not reserved, and a buffered resource has all `BUF_SIZE` slots free.
- R2: `sel_unit_o` is one-hot and equals the highest set bit of the rotation. A cycle with `sel_req_i` removes that bit, so a three-unit set is offered in the order 0100, 0010, 0001.
- R3: When a select or a static claim empties the rotation, the rotation refills in the same cycle, so the unit offered after 0001 is 0100 again.
- R4: With more than one bit in `RES_MASK`, the unit set is `RES_MASK` without its highest set bit. With one bit, the unit set is the low `NUM_UNITS` bits.
- R5: A static claim (`static_req_i` with one-hot `static_unit_i`) of a unit still in the rotation removes that unit from the rotation. A static claim made in the same cycle as `sel_req_i` has no effect.
- R6: A static claim of a unit already gone from the rotation is recorded. At the next refill the recorded units are left out and the record is cleared, so the refill after that restores the whole set. If leaving them out would make the refill empty, the whole set is loaded instead.
- R7: `use_req_i` clears the bit of `use_unit_i` in the free mask, and `rel_req_i` sets the bit of `rel_unit_i`. `ready_o` is high only when the number of free units is at least `need_units_i`.
- R8: `rsv_set_i` sets the reservation and `rsv_clr_i` clears it. Set wins when both are high. While the resource is reserved and `BUF_SIZE` is not 0, `ready_o` is low. When `BUF_SIZE` is 0, the reservation does not affect `ready_o`.
- R9: `status_o` is 0 for dispatch allowed, 1 for buffer full and 2 for reserved. The value 2 appears only when `BUF_SIZE` is 0 and the resource is reserved.
- R10: `buf_take_i` lowers the free-slot count only if it is nonzero, and `buf_give_i` raises it only when `BUF_SIZE` is positive. `status_o` is 1 exactly when the resource is buffered and no slot is free. A resource with `BUF_SIZE` of 0 or -1 never reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_req_i | input | 1 | Take the offered unit and advance the rotation |
| static_req_i | input | 1 | Claim a specific unit statically |
| static_unit_i | input | UNIT_W | One-hot unit being claimed |
| use_req_i | input | 1 | Mark a unit busy |
| use_unit_i | input | UNIT_W | One-hot unit to mark busy |
| rel_req_i | input | 1 | Mark a unit free |
| rel_unit_i | input | UNIT_W | One-hot unit to mark free |
| rsv_set_i | input | 1 | Reserve the resource |
| rsv_clr_i | input | 1 | Drop the reservation |
| buf_take_i | input | 1 | Occupy one buffer slot |
| buf_give_i | input | 1 | Return one buffer slot |
| need_units_i | input | CNT_W | Number of free units requested |
| sel_unit_o | output | UNIT_W | One-hot unit offered next |
| ready_o | output | 1 | Enough free units and not blocked by reservation |
| status_o | output | 2 | 0 dispatch allowed, 1 buffer full, 2 reserved |

## Verification
The checks assume the following about the inputs: a use request names a single unit that is currently free, a release request names a single unit that is currently busy, and no slot is returned to a buffer that is already full. The stimulus keeps track of the free mask and the slot count as it drives them. It releases only units it has used and returns only slots it has taken. It drives the same sequence into a buffered group instance and into a plain-resource instance with `BUF_SIZE` of 0. That sequence is legal for both, because the two instances have the same three-unit set.

// File: rtl/rgs_pkg.sv
package rgs_pkg;
  typedef enum logic [1:0] {
    AV_OK   = 2'd0,
    AV_FULL = 2'd1,
    AV_RSV  = 2'd2
  } avail_e;
endpackage

// File: rtl/rgs_rotor.sv
module rgs_rotor #(
  parameter int                UNIT_W   = 8,
  parameter logic [UNIT_W-1:0] UNIT_SET = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_req_i,
  input  logic              static_req_i,
  input  logic [UNIT_W-1:0] static_unit_i,
  output logic [UNIT_W-1:0] next_unit_o,
  output logic [UNIT_W-1:0] rot_o
);
  logic [UNIT_W-1:0] rot_q, rot_n, rem_q, rem_n, fill;

  always_comb begin
    next_unit_o = '0;
    for (int i = 0; i < UNIT_W; i++) begin
      if (rot_q[i]) begin
        next_unit_o    = '0;
        next_unit_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rot_n = rot_q;
    rem_n = rem_q;
    fill  = '0;
    if (sel_req_i) begin
      rot_n = rot_q & ~next_unit_o;
    end else if (static_req_i) begin
      if ((rot_q & static_unit_i) == '0) rem_n = rem_q | static_unit_i;
      else                               rot_n = rot_q & ~static_unit_i;
    end
    if ((sel_req_i || static_req_i) && rot_n == '0) begin
      fill  = UNIT_SET & ~rem_n;
      rot_n = (fill == '0) ? UNIT_SET : fill;
      rem_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q <= UNIT_SET;
      rem_q <= '0;
    end else begin
      rot_q <= rot_n;
      rem_q <= rem_n;
    end
  end

  assign rot_o = rot_q;
endmodule

// File: rtl/rgs_ready.sv
module rgs_ready #(
  parameter int                UNIT_W   = 8,
  parameter logic [UNIT_W-1:0] UNIT_SET = '1,
  parameter bit                HAZARD   = 1'b0,
  parameter int                CNT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              use_req_i,
  input  logic [UNIT_W-1:0] use_unit_i,
  input  logic              rel_req_i,
  input  logic [UNIT_W-1:0] rel_unit_i,
  input  logic              rsv_set_i,
  input  logic              rsv_clr_i,
  input  logic [CNT_W-1:0]  need_units_i,
  output logic              ready_o,
  output logic              rsv_o,
  output logic [UNIT_W-1:0] rdy_mask_o
);
  logic [UNIT_W-1:0] rdy_q;
  logic              rsv_q;
  logic [CNT_W-1:0]  free_cnt;

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < UNIT_W; i++) free_cnt = free_cnt + CNT_W'(rdy_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= UNIT_SET;
      rsv_q <= 1'b0;
    end else begin
      rdy_q <= rdy_q ^ (use_req_i ? use_unit_i : '0) ^ (rel_req_i ? rel_unit_i : '0);
      if (rsv_set_i)      rsv_q <= 1'b1;
      else if (rsv_clr_i) rsv_q <= 1'b0;
    end
  end

  // a dispatch-hazard resource is always reserved once its user is in flight
  assign ready_o    = (!rsv_q || HAZARD) && (free_cnt >= need_units_i);
  assign rsv_o      = rsv_q;
  assign rdy_mask_o = rdy_q;
endmodule

// File: rtl/rgs_slots.sv
module rgs_slots
  import rgs_pkg::*;
#(
  parameter int BUF_SIZE = 2,
  parameter int SLOT_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              give_i,
  input  logic              rsv_i,
  output logic [SLOT_W-1:0] slots_o,
  output logic [1:0]        status_o
);
  avail_e st;

  generate
    if (BUF_SIZE > 0) begin : g_buf
      logic [SLOT_W-1:0] cnt_q, after_take;
      always_comb after_take = (take_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= SLOT_W'(BUF_SIZE);
        else         cnt_q <= give_i ? after_take + 1'b1 : after_take;
      end
      assign slots_o = cnt_q;
    end else begin : g_nobuf
      logic unused_nobuf;
      assign unused_nobuf = ^{clk_i, rst_ni, take_i, give_i};
      assign slots_o      = '0;
    end
  endgenerate

  always_comb begin
    if (BUF_SIZE == 0 && rsv_i)            st = AV_RSV;
    else if (BUF_SIZE <= 0 || slots_o != '0) st = AV_OK;
    else                                   st = AV_FULL;
  end

  assign status_o = st;
endmodule

// File: rtl/rgs_unit_sel.sv
module rgs_unit_sel #(
  parameter int                UNIT_W    = 8,
  parameter logic [UNIT_W-1:0] RES_MASK  = 'h0F,
  parameter int                NUM_UNITS = 3,
  parameter int                BUF_SIZE  = 2,
  localparam int               CNT_W     = $clog2(UNIT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_req_i,
  input  logic              static_req_i,
  input  logic [UNIT_W-1:0] static_unit_i,
  input  logic              use_req_i,
  input  logic [UNIT_W-1:0] use_unit_i,
  input  logic              rel_req_i,
  input  logic [UNIT_W-1:0] rel_unit_i,
  input  logic              rsv_set_i,
  input  logic              rsv_clr_i,
  input  logic              buf_take_i,
  input  logic              buf_give_i,
  input  logic [CNT_W-1:0]  need_units_i,
  output logic [UNIT_W-1:0] sel_unit_o,
  output logic              ready_o,
  output logic [1:0]        status_o
);
  function automatic logic [UNIT_W-1:0] unit_set_f();
    logic [UNIT_W-1:0] m;
    int                n;
    bit                done;
    m    = '0;
    n    = 0;
    done = 1'b0;
    for (int i = 0; i < UNIT_W; i++) n += int'(RES_MASK[i]);
    if (n > 1) begin
      m = RES_MASK;
      for (int i = UNIT_W - 1; i >= 0; i--) begin
        if (m[i] && !done) begin
          m[i] = 1'b0;
          done = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < UNIT_W; i++) m[i] = (i < NUM_UNITS);
    end
    return m;
  endfunction

  localparam logic [UNIT_W-1:0] UNIT_SET = unit_set_f();
  localparam int SLOT_MAX = (BUF_SIZE > 0) ? BUF_SIZE : 1;
  localparam int SLOT_W   = $clog2(SLOT_MAX + 1);
  localparam bit HAZARD   = (BUF_SIZE == 0);

  logic [UNIT_W-1:0] rot_mask, rdy_mask;
  logic              rsv;
  logic [SLOT_W-1:0] slots;

  rgs_rotor #(.UNIT_W(UNIT_W), .UNIT_SET(UNIT_SET)) u_rotor (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_req_i     (sel_req_i),
    .static_req_i  (static_req_i),
    .static_unit_i (static_unit_i),
    .next_unit_o   (sel_unit_o),
    .rot_o         (rot_mask)
  );

  rgs_ready #(
    .UNIT_W(UNIT_W), .UNIT_SET(UNIT_SET), .HAZARD(HAZARD), .CNT_W(CNT_W)
  ) u_ready (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .use_req_i    (use_req_i),
    .use_unit_i   (use_unit_i),
    .rel_req_i    (rel_req_i),
    .rel_unit_i   (rel_unit_i),
    .rsv_set_i    (rsv_set_i),
    .rsv_clr_i    (rsv_clr_i),
    .need_units_i (need_units_i),
    .ready_o      (ready_o),
    .rsv_o        (rsv),
    .rdy_mask_o   (rdy_mask)
  );

  rgs_slots #(.BUF_SIZE(BUF_SIZE), .SLOT_W(SLOT_W)) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (buf_take_i),
    .give_i   (buf_give_i),
    .rsv_i    (rsv),
    .slots_o  (slots),
    .status_o (status_o)
  );
endmodule

// File: rtl/rgs_unit_sel_chk.sv
module rgs_unit_sel_chk #(
  parameter int                UNIT_W   = 8,
  parameter logic [UNIT_W-1:0] UNIT_SET = '1,
  parameter int                BUF_SIZE = 2,
  parameter int                SLOT_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_req_i,
  input logic              use_req_i,
  input logic [UNIT_W-1:0] use_unit_i,
  input logic              rel_req_i,
  input logic [UNIT_W-1:0] rel_unit_i,
  input logic              buf_give_i,
  input logic [UNIT_W-1:0] sel_unit_o,
  input logic              ready_o,
  input logic [1:0]        status_o,
  input logic [UNIT_W-1:0] rot_q,
  input logic [UNIT_W-1:0] rdy_q,
  input logic              rsv_q,
  input logic [SLOT_W-1:0] slots_q
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_unit_o) == 1); // R2
  AST_SEL_IN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_unit_o & ~UNIT_SET) == '0); // R4
  AST_SEL_DESCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_req_i && $countones(rot_q) > 1) |=> (sel_unit_o < $past(sel_unit_o))); // R2
  AST_SEL_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_req_i && $countones(rot_q) == 1) |=> (sel_unit_o >= $past(sel_unit_o))); // R3
  AST_USE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_req_i |-> ($countones(use_unit_i) == 1 && (rdy_q & use_unit_i) == use_unit_i)); // R7
  AST_REL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_req_i |-> ($countones(rel_unit_i) == 1 && (rdy_q & rel_unit_i) == '0)); // R7
  AST_RSV_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BUF_SIZE != 0 && rsv_q) |-> !ready_o); // R8
  AST_RSV_ONLY_HAZARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd2) |-> (BUF_SIZE == 0 && rsv_q)); // R9
  AST_FULL_MEANS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1) |-> (BUF_SIZE > 0 && slots_q == '0)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_give_i && BUF_SIZE > 0) |-> (int'(slots_q) < BUF_SIZE)); // R10
endmodule

bind rgs_unit_sel rgs_unit_sel_chk #(
  .UNIT_W(UNIT_W), .UNIT_SET(UNIT_SET), .BUF_SIZE(BUF_SIZE), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_req_i  (sel_req_i),
  .use_req_i  (use_req_i),
  .use_unit_i (use_unit_i),
  .rel_req_i  (rel_req_i),
  .rel_unit_i (rel_unit_i),
  .buf_give_i (buf_give_i),
  .sel_unit_o (sel_unit_o),
  .ready_o    (ready_o),
  .status_o   (status_o),
  .rot_q      (rot_mask),
  .rdy_q      (rdy_mask),
  .rsv_q      (rsv),
  .slots_q    (slots)
);

// File: tb/rgs_unit_sel_test.sv
`timescale 1ns/1ps
module rgs_unit_sel_test;
  localparam int UW = 8;
  localparam int CW = $clog2(UW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, st = 0, use_r = 0, rel = 0, rs = 0, rc = 0, take = 0, give = 0;
  logic [UW-1:0] st_u = '0, use_u = '0, rel_u = '0;
  logic [CW-1:0] need = CW'(1);
  logic [UW-1:0] sel_a, sel_b;
  logic rdy_a, rdy_b;
  logic [1:0] st_a, st_b;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // buffered group: mask 0b1111 -> units 0b0111, 2 slots
  rgs_unit_sel #(.UNIT_W(UW), .RES_MASK(8'h0F), .NUM_UNITS(1), .BUF_SIZE(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_req_i(sel), .static_req_i(st), .static_unit_i(st_u),
    .use_req_i(use_r), .use_unit_i(use_u), .rel_req_i(rel), .rel_unit_i(rel_u),
    .rsv_set_i(rs), .rsv_clr_i(rc), .buf_take_i(take), .buf_give_i(give),
    .need_units_i(need), .sel_unit_o(sel_a), .ready_o(rdy_a), .status_o(st_a));

  // plain resource of 3 units, dispatch hazard
  rgs_unit_sel #(.UNIT_W(UW), .RES_MASK(8'h01), .NUM_UNITS(3), .BUF_SIZE(0)) uut_hz (
    .clk_i(clk), .rst_ni(rst_n), .sel_req_i(sel), .static_req_i(st), .static_unit_i(st_u),
    .use_req_i(use_r), .use_unit_i(use_u), .rel_req_i(rel), .rel_unit_i(rel_u),
    .rsv_set_i(rs), .rsv_clr_i(rc), .buf_take_i(take), .buf_give_i(give),
    .need_units_i(need), .sel_unit_o(sel_b), .ready_o(rdy_b), .status_o(st_b));

  typedef struct {int sig; logic [7:0] exp; string tag;} exp_t;
  exp_t q[$];

  function automatic logic [7:0] probe(int s);
    case (s)
      0: return sel_a;
      1: return {7'b0, rdy_a};
      2: return {6'b0, st_a};
      3: return sel_b;
      4: return {7'b0, rdy_b};
      default: return {6'b0, st_b};
    endcase
  endfunction

  task automatic want(int s, logic [7:0] v, string tag);
    q.push_back('{s, v, tag});
  endtask
  task automatic want_sel(logic [7:0] v, string tag);
    want(0, v, tag); want(3, v, tag);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    sel = 0; st = 0; use_r = 0; rel = 0; rs = 0; rc = 0; take = 0; give = 0;
    st_u = '0; use_u = '0; rel_u = '0;
  endtask

  // monitor: compare queued expectations between edges
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e   = q.pop_front();
        act = probe(e.sig);
        checks++;
        if (act !== e.exp) begin
          fails++;
          $display("FAIL %s sig%0d actual=%0h expected=%0h", e.tag, e.sig, act, e.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R4 reset state
    need = CW'(3);
    want_sel(8'h04, "R1 R4 reset unit");
    want(1, 1, "R1 all free"); want(4, 1, "R1 all free hz");
    want(2, 0, "R1 status"); want(5, 0, "R1 status hz");
    tick();
    // R2 rotation order
    sel = 1; want_sel(8'h02, "R2 second"); tick();
    sel = 1; want_sel(8'h01, "R2 third"); tick();
    sel = 1; want_sel(8'h04, "R3 wrap"); tick();
    // R5 static claim of a unit in rotation
    st = 1; st_u = 8'h04; want_sel(8'h02, "R5 static removes"); tick();
    // R5 static ignored with select
    sel = 1; st = 1; st_u = 8'h01; want_sel(8'h01, "R5 static ignored on select"); tick();
    // R6 claim of an absent unit is remembered
    st = 1; st_u = 8'h04; want_sel(8'h01, "R6 absent claim no change"); tick();
    sel = 1; want_sel(8'h02, "R6 reload strips"); tick();
    sel = 1; want_sel(8'h01, "R6 next"); tick();
    sel = 1; want_sel(8'h04, "R6 record cleared"); tick();
    // R3 static empties rotation
    sel = 1; want_sel(8'h02, "R2 step"); tick();
    sel = 1; want_sel(8'h01, "R2 step"); tick();
    st = 1; st_u = 8'h01; want_sel(8'h04, "R3 static reload"); tick();
    // R7 ready mask and count
    use_r = 1; use_u = 8'h02; need = CW'(3);
    want(1, 0, "R7 two free need3"); want(4, 0, "R7 two free need3 hz"); tick();
    need = CW'(2); want(1, 1, "R7 two free need2"); want(4, 1, "R7 hz need2"); tick();
    rel = 1; rel_u = 8'h02; need = CW'(3); want(1, 1, "R7 released"); want(4, 1, "R7 released hz"); tick();
    // R8 R9 reservation
    need = CW'(1);
    rs = 1; want(1, 0, "R8 reserved blocks"); want(4, 1, "R8 hazard ignores");
    want(2, 0, "R9 buffered not rsv"); want(5, 2, "R9 hazard reserved"); tick();
    rs = 1; rc = 1; want(1, 0, "R8 set wins"); want(5, 2, "R8 set wins hz"); tick();
    rc = 1; want(1, 1, "R8 cleared"); want(5, 0, "R9 cleared hz"); tick();
    // R10 buffer slots
    take = 1; want(2, 0, "R10 one slot left"); want(5, 0, "R10 hz unbuffered"); tick();
    take = 1; want(2, 1, "R10 full"); want(5, 0, "R10 hz never full"); tick();
    take = 1; want(2, 1, "R10 take at zero"); tick();
    give = 1; want(2, 0, "R10 give one"); tick();
    take = 1; want(2, 1, "R10 no underflow"); tick();
    give = 1; want(2, 0, "R10 give"); tick();
    give = 1; want(2, 0, "R10 back to two"); tick();
    take = 1; want(2, 0, "R10 depth restored"); tick();
    take = 1; want(2, 1, "R10 depth restored full"); tick();
    give = 1; tick();
    give = 1; tick();
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule